// File: doc/BRIEF.md
# Integer Arithmetic/Logic Unit with Signed and Unsigned Compares

This block is the combinational execute stage of a small three-operand load/store integer core. Each operation takes two sources, operand A and a second operand, and produces one 32-bit result together with a flag that reports an all-zero result. The second operand is either the register value `src_b` or a 16-bit constant widened to 32 bits.

The widening rule depends on the operation. The bitwise operations fill the upper half with zeros. Add, subtract and both compares copy bit 15 of the constant into the upper half. Because the extended constant can be negative, no separate subtract-with-constant operation is needed.

A single adder serves add, subtract and both less-than compares. A staged logical shifter moves operand A by a 5-bit amount. An upper-constant operation builds the top half of a 32-bit constant.

Top module: `int_alu_core`

## Requirements
- R1: Operation code 0 (add) gives A plus the second operand, wrapping modulo 2^32, with no trap.
- R2: Operation code 1 (subtract) gives A minus the second operand modulo 2^32, computed as A plus the inverted operand plus one.
- R3: Operation codes 2 and 3 give the bitwise AND and the bitwise OR of A and the second operand.
- R4: Operation code 4 gives the inverse of (A OR second operand). With a zero second operand this is the bitwise NOT of A.
- R5: Operation code 5 shifts A left by `shamt` positions (0 to 31) and fills the vacated low bits with zeros.
- R6: Operation code 6 shifts A right by `shamt` positions and fills the vacated high bits with zeros.
- R7: Operation code 7 gives exactly 1 when A is less than the second operand, both read as two's-complement numbers, and 0 otherwise. For example, 0xFFFFFFFF compared with 1 gives 1.
- R8: Operation code 8 gives exactly 1 when A is less than the second operand, both read as unsigned numbers, and 0 otherwise. For example, 0xFFFFFFFF compared with 1 gives 0.
- R9: Operation code 9 places bits 15:0 of the second operand in result bits 31:16 and clears result bits 15:0.
- R10: When `imm_sel` is 1, the second operand is `imm_val` widened to 32 bits. It is zero-extended for codes 2, 3 and 4, and extended by replicating bit 15 for all other codes, so the signed range is -32768 to +32767. When `imm_sel` is 0, the second operand is `src_b`.
- R11: `zero` is 1 exactly when the 32-bit result equals 0.
- R12: Operation codes 10 to 15 give a result of 0, so `zero` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation code (see requirements) |
| src_a | input | 32 | Operand A |
| src_b | input | 32 | Register value for the second operand |
| imm_val | input | 16 | Constant field for the second operand |
| imm_sel | input | 1 | 1 selects the widened constant as the second operand |
| shamt | input | 5 | Shift amount for codes 5 and 6 |
| result | output | 32 | Operation result |
| zero | output | 1 | Result equals zero |

## Verification
The embedded checks assume that every input is a known 0 or 1 and that all inputs change together. Under those conditions, the compare outputs of the shared adder and the fill bits of the shifter can be tested against plain relational expressions on the same inputs.

The bench changes all inputs in one step, well away from the sampling edge, so only settled values are compared. The stimulus mixes hand-picked corner values with random vectors:
- all-ones and sign-bit values,
- equal operands,
- shift amounts of 0 and 31,
- constants with bit 15 set,
- undefined operation codes.

// File: rtl/alu_pkg.sv
package alu_pkg;
   localparam int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OP_ADD  = 4'd0,
      OP_SUB  = 4'd1,
      OP_AND  = 4'd2,
      OP_OR   = 4'd3,
      OP_NOR  = 4'd4,
      OP_SLL  = 4'd5,
      OP_SRL  = 4'd6,
      OP_SLT  = 4'd7,
      OP_SLTU = 4'd8,
      OP_LUI  = 4'd9
   } alu_op_e;

   // bitwise operations take a zero-extended constant
   function automatic logic op_is_bitwise(logic [OP_W-1:0] op);
      return (op == OP_AND) || (op == OP_OR) || (op == OP_NOR);
   endfunction

   // operations that run the adder in subtract mode
   function automatic logic op_uses_sub(logic [OP_W-1:0] op);
      return (op == OP_SUB) || (op == OP_SLT) || (op == OP_SLTU);
   endfunction
endpackage

// File: rtl/alu_imm_ext.sv
module alu_imm_ext #(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 16
) (
   input  logic [IMM_W-1:0]  imm_in,
   input  logic              sign_mode,
   output logic [DATA_W-1:0] imm_out
);
   localparam int FILL_W = DATA_W - IMM_W;

   if (FILL_W < 1) begin : g_bad_width
      $error("alu_imm_ext: DATA_W must exceed IMM_W");
   end

   logic fill_bit;

   always_comb begin
      fill_bit = sign_mode & imm_in[IMM_W-1];
      imm_out  = {{FILL_W{fill_bit}}, imm_in};
      // R10: widened constant keeps its low field and fills the top uniformly
      a_r10_fill : assert ((imm_out[IMM_W-1:0] == imm_in) &&
                           ((imm_out >> IMM_W) == ((sign_mode && imm_in[IMM_W-1]) ?
                                                   {{IMM_W{1'b0}}, {FILL_W{1'b1}}} : '0)))
         else $error("a_r10_fill");
   end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  logic              sub_en,
   output logic [DATA_W-1:0] sum,
   output logic              lt_signed,
   output logic              lt_unsigned
);
   localparam int MSB = DATA_W - 1;

   if (DATA_W < 2) begin : g_bad_width
      $error("alu_addsub: DATA_W too small");
   end

   logic [DATA_W-1:0] opb_eff;
   logic [DATA_W:0]   full;
   logic              ovf;

   always_comb begin
      opb_eff     = sub_en ? ~opb : opb;
      full        = {1'b0, opa} + {1'b0, opb_eff} + {{DATA_W{1'b0}}, sub_en};
      sum         = full[MSB:0];
      ovf         = (opa[MSB] == opb_eff[MSB]) && (full[MSB] != opa[MSB]);
      lt_signed   = sub_en & (full[MSB] ^ ovf);
      lt_unsigned = sub_en & ~full[DATA_W];
      // R7: sign/overflow compare matches a two's-complement relation
      a_r7_signed_lt : assert (!sub_en || (lt_signed == ($signed(opa) < $signed(opb))))
         else $error("a_r7_signed_lt");
      // R8: borrow compare matches an unsigned relation
      a_r8_unsigned_lt : assert (!sub_en || (lt_unsigned == (opa < opb)))
         else $error("a_r8_unsigned_lt");
      // R2: equal operands subtract to zero
      a_r2_self_sub : assert (!(sub_en && (opa == opb)) || (sum == '0))
         else $error("a_r2_self_sub");
   end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
   parameter int DATA_W = 32,
   parameter int STYLE  = 0      // 0: log-stage network, 1: direct operator
) (
   input  logic [DATA_W-1:0]         din,
   input  logic [$clog2(DATA_W)-1:0] amt,
   input  logic                      go_left,
   output logic [DATA_W-1:0]         dout
);
   localparam int AMT_W = $clog2(DATA_W);
   localparam int MSB   = DATA_W - 1;

   if ((1 << AMT_W) != DATA_W) begin : g_bad_width
      $error("alu_shift: DATA_W must be a power of two");
   end
   if ((STYLE != 0) && (STYLE != 1)) begin : g_bad_style
      $error("alu_shift: STYLE must be 0 or 1");
   end

   if (STYLE == 0) begin : g_staged
      logic [DATA_W-1:0] stage [AMT_W+1];
      assign stage[0] = din;
      for (genvar k = 0; k < AMT_W; k++) begin : g_stage
         always_comb begin
            if (!amt[k])
               stage[k+1] = stage[k];
            else if (go_left)
               stage[k+1] = stage[k] << (1 << k);
            else
               stage[k+1] = stage[k] >> (1 << k);
         end
      end
      assign dout = stage[AMT_W];
   end else begin : g_direct
      assign dout = go_left ? (din << amt) : (din >> amt);
   end

   always_comb begin
      // R5: a left shift by a nonzero amount empties bit 0
      a_r5_zero_fill : assert (!(go_left && (amt != '0)) || !dout[0])
         else $error("a_r5_zero_fill");
      // R6: a right shift by a nonzero amount empties the top bit
      a_r6_zero_fill : assert (!(!go_left && (amt != '0)) || !dout[MSB])
         else $error("a_r6_zero_fill");
   end
endmodule

// File: rtl/int_alu_core.sv
module int_alu_core
   import alu_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int IMM_W       = 16,
   parameter int SHIFT_STYLE = 0,
   localparam int SHAMT_W    = $clog2(DATA_W)
) (
   input  logic [OP_W-1:0]    op_sel,
   input  logic [DATA_W-1:0]  src_a,
   input  logic [DATA_W-1:0]  src_b,
   input  logic [IMM_W-1:0]   imm_val,
   input  logic               imm_sel,
   input  logic [SHAMT_W-1:0] shamt,
   output logic [DATA_W-1:0]  result,
   output logic               zero
);
   localparam int LOW_W = DATA_W - IMM_W;

   if (LOW_W < 1) begin : g_bad_width
      $error("int_alu_core: DATA_W must exceed IMM_W");
   end

   alu_op_e           op;
   logic [DATA_W-1:0] imm_wide;
   logic [DATA_W-1:0] opnd_b;
   logic [DATA_W-1:0] sum;
   logic              lt_s;
   logic              lt_u;
   logic [DATA_W-1:0] shifted;

   assign op     = alu_op_e'(op_sel);
   assign opnd_b = imm_sel ? imm_wide : src_b;

   alu_imm_ext #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_ext (
      .imm_in    (imm_val),
      .sign_mode (!op_is_bitwise(op_sel)),
      .imm_out   (imm_wide)
   );

   alu_addsub #(.DATA_W(DATA_W)) u_add (
      .opa         (src_a),
      .opb         (opnd_b),
      .sub_en      (op_uses_sub(op_sel)),
      .sum         (sum),
      .lt_signed   (lt_s),
      .lt_unsigned (lt_u)
   );

   alu_shift #(.DATA_W(DATA_W), .STYLE(SHIFT_STYLE)) u_shift (
      .din     (src_a),
      .amt     (shamt),
      .go_left (op == OP_SLL),
      .dout    (shifted)
   );

   always_comb begin
      unique case (op)
         OP_ADD, OP_SUB: result = sum;
         OP_AND:         result = src_a & opnd_b;
         OP_OR:          result = src_a | opnd_b;
         OP_NOR:         result = ~(src_a | opnd_b);
         OP_SLL, OP_SRL: result = shifted;
         OP_SLT:         result = DATA_W'(lt_s);
         OP_SLTU:        result = DATA_W'(lt_u);
         OP_LUI:         result = {opnd_b[IMM_W-1:0], {LOW_W{1'b0}}};
         default:        result = '0;
      endcase
      zero = ~|result;
      // R9: the upper-constant operation leaves the low part clear
      a_r9_lui_low : assert ((op_sel != OP_LUI) || (result[LOW_W-1:0] == '0))
         else $error("a_r9_lui_low");
      // R12: unused operation codes give a zero result
      a_r12_undef : assert ((op_sel <= OP_LUI) || (zero && (result == '0)))
         else $error("a_r12_undef");
      // R7 R8: a compare result is a single 0/1 bit
      a_r7_cmp_bool : assert (!((op_sel == OP_SLT) || (op_sel == OP_SLTU)) ||
                              (result[DATA_W-1:1] == '0))
         else $error("a_r7_cmp_bool");
   end
endmodule

// File: tb/test_int_alu_core.sv
module test_int_alu_core;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  op_sel = '0;
   logic [31:0] src_a = '0;
   logic [31:0] src_b = '0;
   logic [15:0] imm_val = '0;
   logic        imm_sel = 1'b0;
   logic [4:0]  shamt = '0;
   logic [31:0] result;
   logic        zero;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   int_alu_core i_int_alu_core (
      .op_sel (op_sel), .src_a (src_a), .src_b (src_b), .imm_val (imm_val),
      .imm_sel (imm_sel), .shamt (shamt), .result (result), .zero (zero)
   );

   // behavioural reference built from the requirements
   function automatic logic [31:0] model(int op, logic [31:0] a, logic [31:0] b,
                                         logic [15:0] imm, logic isel, int sh);
      logic [31:0] bb;
      longint      s;
      if (isel)
         bb = (op >= 2 && op <= 4) ? {16'h0, imm} : {{16{imm[15]}}, imm};
      else
         bb = b;
      case (op)
         0: begin s = longint'(a) + longint'(bb); return s[31:0]; end
         1: begin s = longint'(a) - longint'(bb); return s[31:0]; end
         2: return a & bb;
         3: return a | bb;
         4: return ~(a | bb);
         5: return a << sh;
         6: return a >> sh;
         7: return ($signed(a) < $signed(bb)) ? 32'd1 : 32'd0;
         8: return (a < bb) ? 32'd1 : 32'd0;
         9: return {bb[15:0], 16'h0};
         default: return 32'h0;
      endcase
   endfunction

   function automatic string op_tag(int op, logic isel);
      if (isel && op != 9 && op <= 8 && op != 5 && op != 6) return "R10";
      case (op)
         0: return "R1";
         1: return "R2";
         2, 3: return "R3";
         4: return "R4";
         5: return "R5";
         6: return "R6";
         7: return "R7";
         8: return "R8";
         9: return "R9";
         default: return "R12";
      endcase
   endfunction

   task automatic apply(int op, logic [31:0] a, logic [31:0] b, logic [15:0] imm,
                        logic isel, int sh, string tag);
      logic [31:0] exp_r;
      @(negedge clk);
      op_sel = 4'(op); src_a = a; src_b = b; imm_val = imm; imm_sel = isel; shamt = 5'(sh);
      exp_r = model(op, a, b, imm, isel, sh);
      @(posedge clk);
      #1;
      checks++;
      if (result !== exp_r) begin
         failures++;
         $display("FAIL %s result op=%0d actual=%h expected=%h", tag, op, result, exp_r);
      end
      checks++;
      if (zero !== (exp_r == 32'h0)) begin
         failures++;
         $display("FAIL R11 zero op=%0d actual=%b expected=%b", op, zero, exp_r == 32'h0);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // reset state: all-zero inputs add to zero (R1, R11)
      #1;
      checks++;
      if (result !== 32'h0 || zero !== 1'b1) begin
         failures++;
         $display("FAIL R11 reset actual=%h/%b expected=00000000/1", result, zero);
      end
      apply(0, 32'hFFFF_FFFF, 32'h1, 16'h0, 0, 0, "R1");
      apply(0, 32'h7FFF_FFFF, 32'h1, 16'h0, 0, 0, "R1");
      apply(1, 32'h0, 32'h2, 16'h0, 0, 0, "R2");
      apply(1, 32'h1234_5678, 32'h1234_5678, 16'h0, 0, 0, "R2");
      apply(2, 32'h0000_0DC0, 32'h0000_3C00, 16'h0, 0, 0, "R3");
      apply(3, 32'h0000_0DC0, 32'h0000_3C00, 16'h0, 0, 0, "R3");
      apply(4, 32'h0000_3C00, 32'h0, 16'h0, 0, 0, "R4");
      apply(5, 32'h8000_0001, 32'h0, 16'h0, 0, 31, "R5");
      apply(5, 32'hA5A5_A5A5, 32'h0, 16'h0, 0, 0, "R5");
      apply(6, 32'h8000_0000, 32'h0, 16'h0, 0, 31, "R6");
      apply(6, 32'hFFFF_FFFF, 32'h0, 16'h0, 0, 4, "R6");
      apply(7, 32'hFFFF_FFFF, 32'h1, 16'h0, 0, 0, "R7");
      apply(7, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 0, 0, "R7");
      apply(7, 32'h5, 32'h5, 16'h0, 0, 0, "R7");
      apply(8, 32'hFFFF_FFFF, 32'h1, 16'h0, 0, 0, "R8");
      apply(8, 32'h1, 32'hFFFF_FFFF, 16'h0, 0, 0, "R8");
      apply(9, 32'h0, 32'h0000_007D, 16'h0, 0, 0, "R9");
      apply(9, 32'h0, 32'h0, 16'h8001, 1, 0, "R9");
      apply(0, 32'h10, 32'h0, 16'hFFFF, 1, 0, "R10");
      apply(1, 32'h10, 32'h0, 16'h8000, 1, 0, "R10");
      apply(2, 32'hFFFF_FFFF, 32'h0, 16'hFFFF, 1, 0, "R10");
      apply(3, 32'h0, 32'h0, 16'h8000, 1, 0, "R10");
      apply(4, 32'h0, 32'h0, 16'h8000, 1, 0, "R10");
      apply(7, 32'h0, 32'h0, 16'hFFFF, 1, 0, "R10");
      apply(8, 32'h0, 32'h0, 16'hFFFF, 1, 0, "R10");
      for (int op = 10; op < 16; op++)
         apply(op, 32'hDEAD_BEEF, 32'h1234_5678, 16'h5A5A, 0, 3, "R12");
      for (int i = 0; i < 3000; i++) begin
         int          op;
         logic [31:0] a;
         logic [31:0] b;
         logic        isel;
         op   = int'($urandom_range(15, 0));
         a    = $urandom;
         b    = ($urandom_range(3, 0) == 0) ? a : $urandom;
         if ($urandom_range(7, 0) == 0) a = 32'hFFFF_FFFF;
         isel = ($urandom_range(3, 0) == 0);
         apply(op, a, b, 16'($urandom), isel, int'($urandom_range(31, 0)), op_tag(op, isel));
      end
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule